// File: doc/BRIEF.md
# Single-Bit Manipulation Unit

This unit carries out single-bit operations of a processor datapath on 16-bit words held in a small register-file model. An operand bit is named by a word address and a 4-bit bit index from 0 to 15. The unit can clear, set, copy or copy-inverted a bit. It can combine a destination bit with a source bit through AND, OR or XOR and write the result back, or compare the two bits and update only the flags. A masked byte update first ANDs either the low or the high byte of a word with an AND mask and then ORs it with an OR mask.

One operation is accepted per clock when `valid` is high. The modified word is written into the register file and the five status flags are registered at the same clock edge, so both are visible one cycle after the operation is presented. A plain load operation fills words so that read-modify-write sequences can be set up. A combinational read port lets any word be observed.

Top module: `bitop_unit`

## Requirements
- R1: After reset, every word of the register file reads 0 and `flags` is 0. The flag bus is packed as flags[4:0] = {E, Z, V, C, N}.
- R2: Op code 9 (load) writes `wr_data` into the word at `dst_addr` and leaves `flags` unchanged.
- R3: Op code 0 (clear) and op code 1 (set) force bit `dst_bit` of word `dst_addr` to 0 or 1 and leave the other 15 bits unchanged. The flags become E=0, V=0, C=0, Z = NOT of the bit's old value, N = the bit's old value.
- R4: Op code 2 (move) copies source bit `src_bit` of word `src_addr` into the destination bit. Op code 3 (move-inverted) copies the inverse of the source bit. For both, Z = NOT of the source bit, N = the source bit, and E, V and C are 0.
- R5: Op codes 4, 5 and 6 write (destination AND source), (destination OR source) and (destination XOR source) into the destination bit. The flags become E=0, Z = NOR, V = OR, C = AND and N = XOR of the two old bits.
- R6: Op code 7 (compare) sets the flags exactly as R5 does and leaves every word unchanged.
- R7: Op code 8 (byte update) replaces one byte of word `dst_addr` with (byte AND `and_mask`) OR `or_mask`. With `hi_byte`=1 the byte is bits 15:8, and with `hi_byte`=0 it is bits 7:0. The other byte and `flags` are unchanged. A bit cleared by the AND mask ends up 1 when its OR-mask bit is 1.
- R8: Results appear on `rd_data` and `flags` after the clock edge that samples `valid`=1. While `valid` is 0, nothing changes. When the source and destination are in the same word, the source bit is taken from the word as it was before the write.
- R9: Op codes 10 to 15 change neither any word nor `flags`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid | input | 1 | Operation strobe |
| op | input | 4 | Operation code |
| dst_addr | input | AW | Destination word address |
| dst_bit | input | 4 | Destination bit index |
| src_addr | input | AW | Source word address |
| src_bit | input | 4 | Source bit index |
| and_mask | input | 8 | AND mask for the byte update |
| or_mask | input | 8 | OR mask for the byte update |
| hi_byte | input | 1 | Byte select for the byte update |
| wr_data | input | 16 | Load data |
| rd_addr | input | AW | Read port address |
| rd_data | output | 16 | Word at `rd_addr` |
| flags | output | 5 | Registered {E, Z, V, C, N} |

## Verification
Two functions meet in the same cycle when the source read and the destination write land on one word. The bench provokes this by pointing both operands at the same address, once with different bit indices and once with the same bit. It judges the outcome with a model that takes the source bit from the pre-write word, then compares the stored word and the flags one cycle later. Back-to-back operations on one word check that the second operation sees the result written by the first.

// File: rtl/bitop_unit.sv
module bitop_unit #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid,
  input  logic [3:0]    op,
  input  logic [AW-1:0] dst_addr,
  input  logic [3:0]    dst_bit,
  input  logic [AW-1:0] src_addr,
  input  logic [3:0]    src_bit,
  input  logic [7:0]    and_mask,
  input  logic [7:0]    or_mask,
  input  logic          hi_byte,
  input  logic [15:0]   wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [15:0]   rd_data,
  output logic [4:0]    flags
);
  localparam int WORDS = 1 << AW;
  localparam logic [3:0] OP_CLR = 4'd0, OP_SET = 4'd1, OP_MOV = 4'd2, OP_MOVN = 4'd3,
                         OP_AND = 4'd4, OP_OR = 4'd5, OP_XOR = 4'd6, OP_CMP = 4'd7,
                         OP_FLD = 4'd8, OP_LD = 4'd9;

  logic [15:0] mem [WORDS];
  logic [15:0] nw;
  logic [4:0]  nf;
  logic        we;

  wire [15:0] dw = mem[dst_addr];
  wire [15:0] sw = mem[src_addr];
  wire        db = dw[dst_bit];
  wire        sb = sw[src_bit];
  wire [4:0]  lf = {1'b0, ~(db | sb), db | sb, db & sb, db ^ sb};

  assign rd_data = mem[rd_addr];

  always_comb begin
    nw = dw;
    nf = flags;
    we = 1'b0;
    case (op)
      OP_CLR, OP_SET: begin
        nw[dst_bit] = (op == OP_SET);
        nf = {1'b0, ~db, 1'b0, 1'b0, db};
        we = 1'b1;
      end
      OP_MOV, OP_MOVN: begin
        nw[dst_bit] = (op == OP_MOVN) ? ~sb : sb;
        nf = {1'b0, ~sb, 1'b0, 1'b0, sb};
        we = 1'b1;
      end
      OP_AND: begin nw[dst_bit] = db & sb; nf = lf; we = 1'b1; end
      OP_OR:  begin nw[dst_bit] = db | sb; nf = lf; we = 1'b1; end
      OP_XOR: begin nw[dst_bit] = db ^ sb; nf = lf; we = 1'b1; end
      OP_CMP: nf = lf;
      OP_FLD: begin
        if (hi_byte) nw[15:8] = (dw[15:8] & and_mask) | or_mask;
        else         nw[7:0]  = (dw[7:0]  & and_mask) | or_mask;
        we = 1'b1;
      end
      OP_LD: begin nw = wr_data; we = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
      flags <= '0;
    end else if (valid) begin
      if (we) mem[dst_addr] <= nw;
      flags <= nf;
    end
  end

  // R3 / R4: single-bit flag form
  a_r3_single_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && op <= OP_MOVN) |=> (flags[4] == 1'b0 && flags[2:1] == 2'b00 && flags[3] == !flags[0]));

  // R5: two-bit flag consistency
  a_r5_pair_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && op >= OP_AND && op <= OP_CMP) |=>
      (flags[4] == 1'b0 && flags[3] == !flags[2] && (!flags[1] || flags[2]) && flags[0] == (flags[2] && !flags[1])));

  // R6: compare leaves the word unchanged
  a_r6_cmp_nowrite: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && op == OP_CMP) |=> (mem[$past(dst_addr)] == $past(mem[dst_addr])));

  // R7: the unselected byte is kept
  a_r7_other_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && op == OP_FLD) |=>
      ($past(hi_byte) ? (mem[$past(dst_addr)][7:0] == $past(dw[7:0]))
                      : (mem[$past(dst_addr)][15:8] == $past(dw[15:8]))));

  // R8: flags hold while idle
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> $stable(flags));

  // R9: unused codes change nothing
  a_r9_unused: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && op > OP_LD) |=> ($stable(flags) && mem[$past(dst_addr)] == $past(mem[dst_addr])));
endmodule

// File: tb/bitop_unit_tb.sv
module bitop_unit_tb;
  localparam int AW = 3;
  logic clk = 0, rst_n = 0, valid = 0, hi_byte = 0;
  logic [3:0] op = 0, dst_bit = 0, src_bit = 0;
  logic [AW-1:0] dst_addr = 0, src_addr = 0, rd_addr = 0;
  logic [7:0] and_mask = 0, or_mask = 0;
  logic [15:0] wr_data = 0, rd_data;
  logic [4:0] flags;
  int tests = 0, fails = 0;
  logic [15:0] em [8];
  logic [4:0] ef;

  always #2 clk = ~clk;

  bitop_unit #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .valid(valid), .op(op), .dst_addr(dst_addr), .dst_bit(dst_bit),
    .src_addr(src_addr), .src_bit(src_bit), .and_mask(and_mask), .or_mask(or_mask),
    .hi_byte(hi_byte), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .flags(flags));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [3:0] o, input int da, input int dbt, input int sa, input int sbt,
                     input logic [7:0] am, input logic [7:0] om, input logic hi,
                     input logic [15:0] wd, input string tag);
    logic [15:0] w, s;
    logic d, b;
    w = em[da]; s = em[sa]; d = w[dbt]; b = s[sbt];
    case (o)
      0: begin w[dbt] = 1'b0; ef = {1'b0, !d, 2'b00, d}; end
      1: begin w[dbt] = 1'b1; ef = {1'b0, !d, 2'b00, d}; end
      2: begin w[dbt] = b;  ef = {1'b0, !b, 2'b00, b}; end
      3: begin w[dbt] = !b; ef = {1'b0, !b, 2'b00, b}; end
      4, 5, 6, 7: begin
        if (o == 4) w[dbt] = d & b;
        if (o == 5) w[dbt] = d | b;
        if (o == 6) w[dbt] = d ^ b;
        ef = {1'b0, !(d | b), d | b, d & b, d ^ b};
      end
      8: if (hi) w[15:8] = (w[15:8] & am) | om; else w[7:0] = (w[7:0] & am) | om;
      9: w = wd;
      default: ;
    endcase
    @(negedge clk);
    op = o; dst_addr = da[AW-1:0]; dst_bit = dbt[3:0]; src_addr = sa[AW-1:0]; src_bit = sbt[3:0];
    and_mask = am; or_mask = om; hi_byte = hi; wr_data = wd; rd_addr = da[AW-1:0]; valid = 1;
    @(negedge clk);
    valid = 0;
    em[da] = w;
    if (tag != "") begin
      chk({tag, " word"}, rd_data, w);
      chk({tag, " flags"}, {11'd0, flags}, {11'd0, ef});
    end
  endtask

  task automatic load(input int a, input logic [15:0] v);
    run(4'd9, a, 0, a, 0, 8'h00, 8'h00, 1'b0, v, "");
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) em[i] = 16'h0;
    ef = 5'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rd_addr = i[AW-1:0]; #0.1;
      chk("R1 reset word", rd_data, 16'h0);
    end
    chk("R1 reset flags", {11'd0, flags}, 16'h0);

    run(4'd9, 3, 0, 3, 0, 8'h00, 8'h00, 1'b0, 16'hBEEF, "R2 load");

    for (int b = 0; b < 16; b++)
      for (int c = 0; c < 4; c++) begin
        for (int o = 0; o < 8; o++) begin
          logic [15:0] dv, sv;
          dv = 16'hA5C3; dv[b] = c[0];
          sv = 16'h3C5A; sv[15-b] = c[1];
          load(2, dv);
          load(1, sv);
          case (o)
            0, 1:    run(o[3:0], 2, b, 1, 15-b, 8'h00, 8'h00, 1'b0, 16'h0, "R3 clr/set");
            2, 3:    run(o[3:0], 2, b, 1, 15-b, 8'h00, 8'h00, 1'b0, 16'h0, "R4 mov");
            4, 5, 6: run(o[3:0], 2, b, 1, 15-b, 8'h00, 8'h00, 1'b0, 16'h0, "R5 logic");
            default: run(o[3:0], 2, b, 1, 15-b, 8'h00, 8'h00, 1'b0, 16'h0, "R6 cmp");
          endcase
        end
      end

    load(4, 16'h5AA5);
    run(4'd8, 4, 0, 4, 0, 8'h00, 8'h01, 1'b0, 16'h0, "R7 and0/or1 low");
    run(4'd8, 4, 0, 4, 0, 8'h0F, 8'h80, 1'b1, 16'h0, "R7 high");
    run(4'd8, 4, 0, 4, 0, 8'hF0, 8'h00, 1'b0, 16'h0, "R7 low clear");
    run(4'd8, 4, 0, 4, 0, 8'hFF, 8'h00, 1'b1, 16'h0, "R7 identity");
    run(4'd8, 4, 0, 4, 0, 8'h00, 8'hFF, 1'b1, 16'h0, "R7 and0/or1 all high");

    load(5, 16'h0001);
    run(4'd2, 5, 7, 5, 0, 8'h00, 8'h00, 1'b0, 16'h0, "R8 same word mov");
    run(4'd6, 5, 0, 5, 0, 8'h00, 8'h00, 1'b0, 16'h0, "R8 same bit xor");
    run(4'd3, 5, 3, 5, 7, 8'h00, 8'h00, 1'b0, 16'h0, "R8 back-to-back");

    @(negedge clk);
    op = 4'd1; dst_addr = 3'd6; dst_bit = 4'd4; rd_addr = 3'd6; valid = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R8 idle word", rd_data, em[6]);
    chk("R8 idle flags", {11'd0, flags}, {11'd0, ef});

    load(7, 16'h1234);
    for (int o = 10; o < 16; o++)
      run(o[3:0], 7, 2, 7, 5, 8'h00, 8'hFF, 1'b0, 16'hFFFF, "R9 unused");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule